// File: doc/BRIEF.md
# Dual-Filter Row Activation Blacklister

This block watches the row activations of one DRAM bank and estimates, for any row, how often it has been opened during the recent past. It holds two counting Bloom filters, each an array of saturating counters indexed by several XOR-matrix hashes of the row address. Every activation bumps the hashed counters in both filters. Only one filter, the active one, answers lookups. The other, the passive one, only collects counts. A lookup takes the smallest of the row's hashed counters in the active filter and flags the row when that figure has reached a programmable threshold. A scheduler can then hold back further activations of a flagged row.

An epoch tick swaps the two roles. The filter that was active is zeroed at that same edge and starts over as the passive one. The filter that was passive becomes active and keeps the epoch of history it has already gathered. The estimate can come out too high when rows alias onto the same counters, but it can never come out too low. One instance serves one bank.

Top module: `rhb_blacklister`

## Requirements
- R1: Every accepted activation (`act_valid` high) raises the hashed counters of its row in both filters, so the passive filter's count becomes visible once it turns active.
- R2: After reset, filter A is active and every counter is zero. With a threshold of 1 or more, no row is flagged.
- R3: An `epoch_tick` sampled at a clock edge swaps the active and passive roles from the next cycle onward. Without a tick the roles stay as they are.
- R4: At a swap, the outgoing active filter is cleared to zero in that one edge. The incoming active filter keeps its counts.
- R5: `qry_black` is high exactly when the estimate (the minimum over the row's hashed counters in the active filter) is greater than or equal to `cfg_thresh`. The estimate never falls below the true count of activations since the active filter was last cleared.
- R6: Hash h computes its index as the XOR of the seed words of all address bits that are set. The seed word for hash h and address bit b is `cfg_seed[(h*ROW_W+b)*IDX_W +: IDX_W]`. An address bit whose seed words are zero in every hash does not change the row's indices.
- R7: Counters saturate at 2^CNT_W-1 and never wrap.
- R8: When an insertion and a tick fall in the same cycle, the insertion is applied after the swap. The freshly cleared filter therefore holds 1 at that row's counters.
- R9: `qry_black` is combinational from the registered state. A query in the same cycle as an insertion of that row sees the count before the insertion.
- R10: When several hashes of one row land on the same counter, that counter rises by one for the activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | An activation occurs this cycle |
| act_row | input | ROW_W | Row address of the activation |
| epoch_tick | input | 1 | Swap filter roles at this edge |
| qry_row | input | ROW_W | Row address to look up |
| qry_black | output | 1 | Looked-up row is flagged |
| cfg_thresh | input | CNT_W | Blacklisting threshold |
| cfg_seed | input | NUM_HASH*ROW_W*IDX_W | Hash seed words |

## Verification
A single row is hammered up to the threshold. This separates an estimate taken before the insertion from one taken after it, and `>=` from `>`. Counts are split across a tick, with a tick landing in the same cycle as an insertion. This shows whether the passive filter collects counts, which filter is cleared, and in what order the swap and the insertion are applied. Zero seed words on one address bit force aliasing, which tests the hash formula and the allowed over-estimate. A long run past 255 activations exposes wrapping. A mixed stream of a few hot rows, with periodic ticks and lookups of random rows, is compared against the reference model on every cycle.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
    typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} side_e;

    typedef struct packed {
        side_e active;
    } ctl_t;
endpackage

// File: rtl/rhb_h3_hash.sv
module rhb_h3_hash #(
    parameter int ROW_W = 16,
    parameter int IDX_W = 10
) (
    input  logic [ROW_W-1:0]       row_i,
    input  logic [ROW_W*IDX_W-1:0] seed_i,
    output logic [IDX_W-1:0]       idx_o
);
    always_comb begin
        idx_o = '0;
        for (int b = 0; b < ROW_W; b++) begin
            if (row_i[b]) idx_o = idx_o ^ seed_i[b*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/rhb_hash_bank.sv
module rhb_hash_bank #(
    parameter int ROW_W    = 16,
    parameter int IDX_W    = 10,
    parameter int NUM_HASH = 4
) (
    input  logic [ROW_W-1:0]                row_i,
    input  logic [NUM_HASH*ROW_W*IDX_W-1:0] seed_i,
    output logic [NUM_HASH*IDX_W-1:0]       idx_o
);
    localparam int SEED_W = ROW_W * IDX_W;

    for (genvar h = 0; h < NUM_HASH; h++) begin : g_hash
        rhb_h3_hash #(.ROW_W(ROW_W), .IDX_W(IDX_W)) u_hash (
            .row_i  (row_i),
            .seed_i (seed_i[h*SEED_W +: SEED_W]),
            .idx_o  (idx_o[h*IDX_W +: IDX_W])
        );
    end
endmodule

// File: rtl/rhb_cbf.sv
module rhb_cbf #(
    parameter int IDX_W    = 10,
    parameter int NUM_HASH = 4,
    parameter int CNT_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_i,
    input  logic                      ins_i,
    input  logic [NUM_HASH*IDX_W-1:0] ins_idx_i,
    input  logic [NUM_HASH*IDX_W-1:0] q_idx_i,
    output logic [CNT_W-1:0]          est_o
);
    localparam int               DEPTH = 1 << IDX_W;
    localparam logic [CNT_W-1:0] MAX   = '1;

    logic [CNT_W-1:0] cnt_d [DEPTH];
    logic [CNT_W-1:0] cnt_q [DEPTH];

    // next value: clear first, then the insertion on top (saturating)
    always_comb begin
        for (int j = 0; j < DEPTH; j++) begin
            logic             hit;
            logic [CNT_W-1:0] base;
            hit = 1'b0;
            for (int h = 0; h < NUM_HASH; h++) begin
                if (ins_idx_i[h*IDX_W +: IDX_W] == IDX_W'(j)) hit = 1'b1;
            end
            base     = clr_i ? '0 : cnt_q[j];
            cnt_d[j] = (ins_i && hit && base != MAX) ? base + 1'b1 : base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) cnt_q[j] <= '0;
        end else begin
            for (int j = 0; j < DEPTH; j++) cnt_q[j] <= cnt_d[j];
        end
    end

    // minimum over the hashed counters of the queried row
    always_comb begin
        est_o = MAX;
        for (int h = 0; h < NUM_HASH; h++) begin
            if (cnt_q[q_idx_i[h*IDX_W +: IDX_W]] < est_o)
                est_o = cnt_q[q_idx_i[h*IDX_W +: IDX_W]];
        end
    end

    // R1: an insertion of the queried counter set raises its minimum
    a_r1_insert_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_i && !clr_i && ins_idx_i == q_idx_i && est_o != MAX)
        |=> ($stable(q_idx_i) -> est_o > $past(est_o)));

    // R4: after a clear no counter exceeds one (at most one insertion on top)
    a_r4_clear_bound: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> est_o <= CNT_W'(1));

    // R7: without a clear the estimate never drops (no wrap at saturation)
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ($stable(q_idx_i) -> est_o >= $past(est_o)));
endmodule

// File: rtl/rhb_blacklister.sv
module rhb_blacklister
    import rhb_pkg::*;
#(
    parameter int ROW_W    = 16,
    parameter int IDX_W    = 10,
    parameter int NUM_HASH = 4,
    parameter int CNT_W    = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            act_valid,
    input  logic [ROW_W-1:0]                act_row,
    input  logic                            epoch_tick,
    input  logic [ROW_W-1:0]                qry_row,
    output logic                            qry_black,
    input  logic [CNT_W-1:0]                cfg_thresh,
    input  logic [NUM_HASH*ROW_W*IDX_W-1:0] cfg_seed
);
    localparam int HIDX_W = NUM_HASH * IDX_W;

    ctl_t ctl_d, ctl_q;

    logic [HIDX_W-1:0] ins_idx, q_idx;
    logic [CNT_W-1:0]  est_a, est_b, est_act;
    logic              clr_a, clr_b;

    rhb_hash_bank #(.ROW_W(ROW_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) u_hash_ins (
        .row_i (act_row), .seed_i (cfg_seed), .idx_o (ins_idx)
    );
    rhb_hash_bank #(.ROW_W(ROW_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH)) u_hash_qry (
        .row_i (qry_row), .seed_i (cfg_seed), .idx_o (q_idx)
    );

    always_comb begin
        ctl_d = ctl_q;
        clr_a = 1'b0;
        clr_b = 1'b0;
        if (epoch_tick) begin
            clr_a        = (ctl_q.active == SIDE_A);
            clr_b        = (ctl_q.active == SIDE_B);
            ctl_d.active = (ctl_q.active == SIDE_A) ? SIDE_B : SIDE_A;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{active: SIDE_A};
        else        ctl_q <= ctl_d;
    end

    rhb_cbf #(.IDX_W(IDX_W), .NUM_HASH(NUM_HASH), .CNT_W(CNT_W)) u_cbf_a (
        .clk (clk), .rst_n (rst_n), .clr_i (clr_a), .ins_i (act_valid),
        .ins_idx_i (ins_idx), .q_idx_i (q_idx), .est_o (est_a)
    );
    rhb_cbf #(.IDX_W(IDX_W), .NUM_HASH(NUM_HASH), .CNT_W(CNT_W)) u_cbf_b (
        .clk (clk), .rst_n (rst_n), .clr_i (clr_b), .ins_i (act_valid),
        .ins_idx_i (ins_idx), .q_idx_i (q_idx), .est_o (est_b)
    );

    assign est_act   = (ctl_q.active == SIDE_A) ? est_a : est_b;
    assign qry_black = (est_act >= cfg_thresh);

    // R3: a tick flips the role, no tick keeps it
    a_r3_role_flip: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_tick |=> ctl_q.active != $past(ctl_q.active));
    a_r3_role_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !epoch_tick |=> $stable(ctl_q.active));

    // R5: a flagged row stays flagged while the active filter is not cleared
    a_r5_stays_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (!epoch_tick && qry_black)
        |=> (($stable(qry_row) && $stable(cfg_thresh) && $stable(cfg_seed)) -> qry_black));
endmodule

// File: tb/tb_rhb_blacklister.sv
module tb_rhb_blacklister;
    localparam int ROW_W = 16, IDX_W = 10, NUM_HASH = 4, CNT_W = 8;
    localparam int DEPTH = 1 << IDX_W;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic act_valid = 1'b0, epoch_tick = 1'b0;
    logic [ROW_W-1:0] act_row = '0, qry_row = '0;
    logic [CNT_W-1:0] cfg_thresh = '0;
    logic [NUM_HASH*ROW_W*IDX_W-1:0] cfg_seed = '0;
    logic qry_black;

    rhb_blacklister #(.ROW_W(ROW_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_row(act_row),
        .epoch_tick(epoch_tick), .qry_row(qry_row), .qry_black(qry_black),
        .cfg_thresh(cfg_thresh), .cfg_seed(cfg_seed)
    );

    always #5 clk = ~clk;

    int cnt_m [2][DEPTH];
    int act_side = 0;
    int n_vec = 0, n_bad = 0;
    string tag = "R2";
    int unsigned lcg = 32'h1234_5678;

    function automatic int hidx(int h, logic [ROW_W-1:0] row);
        logic [IDX_W-1:0] acc = '0;
        for (int b = 0; b < ROW_W; b++)
            if (row[b]) acc ^= cfg_seed[(h*ROW_W+b)*IDX_W +: IDX_W];
        return int'(acc);
    endfunction

    function automatic int est_m(logic [ROW_W-1:0] row);
        int m = CMAX;
        for (int h = 0; h < NUM_HASH; h++)
            if (cnt_m[act_side][hidx(h, row)] < m) m = cnt_m[act_side][hidx(h, row)];
        return m;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 2; s++) for (int j = 0; j < DEPTH; j++) cnt_m[s][j] = 0;
        act_side = 0;
    endtask

    task automatic model_update(bit a, logic [ROW_W-1:0] r, bit t);
        int seen [NUM_HASH];
        if (t) begin
            for (int j = 0; j < DEPTH; j++) cnt_m[act_side][j] = 0;
            act_side = 1 - act_side;
        end
        if (a) begin
            for (int h = 0; h < NUM_HASH; h++) begin
                bit dup = 1'b0;
                seen[h] = hidx(h, r);
                for (int k = 0; k < h; k++) if (seen[k] == seen[h]) dup = 1'b1;
                if (!dup)
                    for (int s = 0; s < 2; s++)
                        if (cnt_m[s][seen[h]] < CMAX) cnt_m[s][seen[h]]++;
            end
        end
    endtask

    task automatic step(bit a, logic [ROW_W-1:0] r, bit t, logic [ROW_W-1:0] q);
        bit exp_b;
        @(negedge clk);
        act_valid = a; act_row = r; epoch_tick = t; qry_row = q;
        #1;
        exp_b = (est_m(q) >= int'(cfg_thresh));
        n_vec++;
        if (qry_black !== exp_b) begin
            n_bad++;
            $display("FAIL %s: row %h got %b expected %b at %0t", tag, q, qry_black, exp_b, $time);
        end
        model_update(a, r, t);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; act_valid = 1'b0; epoch_tick = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic seed_normal();
        for (int h = 0; h < NUM_HASH; h++)
            for (int b = 0; b < ROW_W; b++)
                cfg_seed[(h*ROW_W+b)*IDX_W +: IDX_W] = IDX_W'((h*977 + b*131 + 7) ^ (b << h) ^ (h*b*29));
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [ROW_W-1:0] x = 16'h3A5C, y = 16'h0F13;
        seed_normal();
        cfg_thresh = 8'd1;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state, nothing flagged
        tag = "R2";
        step(0, 0, 0, x); step(0, 0, 0, y);

        // R5 and R9: hammer x up to threshold 4; same-cycle query sees old count
        tag = "R9"; cfg_thresh = 8'd4;
        for (int i = 0; i < 4; i++) step(1, x, 0, x);
        tag = "R5";
        step(0, 0, 0, x); step(0, 0, 0, y);

        // R1 and R4: passive side collects counts, outgoing side is cleared
        do_reset();
        tag = "R1";
        for (int i = 0; i < 3; i++) step(1, x, 0, x);
        step(0, 0, 1, x);            // swap: A cleared, B active with 3
        tag = "R4";
        step(0, 0, 0, x);            // 3 < 4
        step(1, x, 0, x);
        step(0, 0, 0, x);            // B reaches 4
        tag = "R3";
        step(0, 0, 1, x);            // swap back: A active with 1
        step(0, 0, 0, x);

        // R8: insertion together with tick lands in freshly cleared filter
        do_reset();
        tag = "R8"; cfg_thresh = 8'd1;
        step(1, y, 1, y);            // A cleared then +1, B active +1
        step(0, 0, 0, y);
        step(0, 0, 1, y);            // A active again with its 1
        step(0, 0, 0, y);
        step(0, 0, 1, y);            // B was cleared: 0
        step(0, 0, 0, y);

        // R6 and R10: zero seed words on bit 5 alias x with x^bit5
        do_reset();
        tag = "R6";
        for (int h = 0; h < NUM_HASH; h++) cfg_seed[(h*ROW_W+5)*IDX_W +: IDX_W] = '0;
        for (int h = 0; h < NUM_HASH; h++) cfg_seed[(h*ROW_W+2)*IDX_W +: IDX_W] = IDX_W'(h*2 + 1);
        cfg_thresh = 8'd2;
        step(1, x, 0, x ^ 16'h0020); step(1, x, 0, x ^ 16'h0020);
        step(0, 0, 0, x ^ 16'h0020); step(0, 0, 0, x ^ 16'h0040);
        tag = "R10";
        for (int h = 0; h < NUM_HASH; h++)
            for (int b = 0; b < ROW_W; b++) cfg_seed[(h*ROW_W+b)*IDX_W +: IDX_W] = IDX_W'(b*3 + 1);
        do_reset();
        cfg_thresh = 8'd2;
        step(1, y, 0, y); step(0, 0, 0, y);
        cfg_thresh = 8'd1;
        step(0, 0, 0, y);

        // R7: saturation, no wrap after 300 insertions
        seed_normal();
        do_reset();
        tag = "R7"; cfg_thresh = 8'd255;
        for (int i = 0; i < 300; i++) step(1, x, 0, x);
        step(0, 0, 0, x);

        // R5: mixed hot-row traffic with periodic swaps
        do_reset();
        tag = "R5"; cfg_thresh = 8'd6;
        for (int i = 0; i < 1500; i++) begin
            logic [ROW_W-1:0] r, q;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            r = ROW_W'(16'h1100 + (lcg[20:18] * 16'h0123));
            q = ROW_W'(16'h1100 + (lcg[27:25] * 16'h0123));
            step(lcg[30], r, (i % 40) == 39, q);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule